// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit picks the smaller or the larger of two 64-bit binary floating-point operands. A 4-bit mode field sets three things: minimum or maximum, signed or magnitude comparison, and one of four rules for handling NaN operands. The same comparator serves all sixteen mode values. Ties and signed zeros follow fixed rules, so the result bit pattern is fully determined.

The unit also reports whether either operand was a signalling NaN. It takes in the current invalid-operation and exception-summary status bits and returns their updated values. It decides whether the result may be written to the destination register or whether an enabled-exception trap must be raised in its place. It forms a 4-bit condition summary for the condition register. Each operation is accepted with `valid_i` and comes back one clock later with `valid_o`.

Top module: `fp_minmax_unit`

## Requirements
- R1: An operation presented with `valid_i` high at a rising clock edge appears on the outputs with `valid_o` high after that edge. `valid_o` is low after a cycle with `valid_i` low, and low after reset.
- R2: An operand is a NaN when bits 62:52 are all ones and bits 51:0 are not zero. It is signalling when bit 51 is also zero. `snan_o` is high when either operand is signalling. Quieting a NaN sets bit 51 and leaves every other bit unchanged.
- R3: Mode bits 1:0 = 00 (2008 number policy): a signalling a gives quieted a; failing that, a signalling b gives quieted b; failing that, two NaNs give quieted a; failing that, one NaN gives the other operand.
- R4: Mode bits 1:0 = 01 (2019 propagating policy): a NaN a gives quieted a; failing that, a NaN b gives quieted b.
- R5: Mode bits 1:0 = 10 (2019 number policy): two NaNs give quieted a. A single NaN, signalling or quiet, gives the other operand unchanged.
- R6: Mode bits 1:0 = 11 (C-style policy): any NaN operand gives b unchanged. Two zeros of any sign also give b.
- R7: In the policies other than C-style, two zero operands give a AND b for maximum (mode bit 3 = 1) and a OR b for minimum.
- R8: With mode bit 2 = 1 (magnitude), the sign bits are dropped from the comparison only when the absolute values differ. Otherwise a signed comparison is made.
- R9: If no rule above applies, a is returned when a < b (minimum) or a > b (maximum). Otherwise b is returned, and this includes equal values.
- R10: `vxsnan_o` = `vxsnan_i` OR `snan_o`. `fx_o` = `fx_i` OR (`snan_o` AND NOT `vxsnan_i`).
- R11: `wr_en_o` is high when `ve_i` is low or no signalling NaN was seen. Otherwise `trap_o` is high. The two are never high together, and both are low while `valid_o` is low.
- R12: `cr_o` = {`fx_o`, FEX, VX, `ox_i`}, with bit 3 first. VX = `vxsnan_o` OR `vx_other_i`. FEX = `fex_other_i` OR (VX AND `ve_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| mode_i | input | 4 | {max, magnitude, nan_policy[1:0]} |
| fx_i | input | 1 | Current exception summary bit |
| vxsnan_i | input | 1 | Current invalid-sNaN status bit |
| vx_other_i | input | 1 | OR of the other invalid-operation status bits |
| fex_other_i | input | 1 | Enabled-exception summary from other sources |
| ox_i | input | 1 | Current overflow status bit |
| ve_i | input | 1 | Invalid-operation exception enable |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Selected value |
| snan_o | output | 1 | A signalling NaN operand was seen |
| wr_en_o | output | 1 | Result may be written back |
| trap_o | output | 1 | Enabled invalid exception, writeback suppressed |
| fx_o | output | 1 | Updated exception summary bit |
| vxsnan_o | output | 1 | Updated invalid-sNaN status bit |
| cr_o | output | 4 | Condition summary {FX, FEX, VX, OX} |

## Verification
The unit holds no state between operations apart from the output register. A wrong decision inside it therefore shows at the ports in the very next `valid_o` cycle: as a wrong result pattern, as a wrong quiet bit on a NaN, or as a wrong status, writeback or trap bit. The bench compares every port on every accepted operation against a model that uses real-number comparison. It sweeps all sixteen modes over zeros of both signs, finite values, infinities, and quiet and signalling NaNs of both signs. It also rotates the incoming status bits, so that the sticky-bit and trap decisions are checked with each operand pair.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  localparam int FP_W  = 64;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;

  typedef enum logic [1:0] {
    POL_NUM08  = 2'b00,
    POL_PROP19 = 2'b01,
    POL_NUM19  = 2'b10,
    POL_CSTYLE = 2'b11
  } nan_pol_e;

  typedef struct packed {
    logic     is_max;
    logic     is_mag;
    nan_pol_e pol;
  } mode_t;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } cls_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic [W-1:0]   op_i,
  output fmm_pkg::cls_t  cls_o,
  output logic [W-1:0]   quiet_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = op_i[W-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];

  always_comb begin
    cls_o.nan  = (&exp_f) && (|man_f);
    cls_o.snan = cls_o.nan && !man_f[MAN_W-1];
    cls_o.zero = ~|op_i[W-2:0];
    quiet_o    = op_i;
    quiet_o[MAN_W-1] = 1'b1;
  end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         is_max_i,
  input  logic         is_mag_i,
  output logic         pick_a_o
);
  // sign-magnitude -> monotonic unsigned key
  function automatic logic [W-1:0] to_key(input logic [W-1:0] x);
    return x[W-1] ? ~x : {1'b1, x[W-2:0]};
  endfunction

  logic [W-1:0] abs_a, abs_b, ka, kb;
  logic         use_abs, lt, gt;

  always_comb begin
    abs_a   = {1'b0, a_i[W-2:0]};
    abs_b   = {1'b0, b_i[W-2:0]};
    use_abs = is_mag_i && (abs_a != abs_b);
    ka      = to_key(use_abs ? abs_a : a_i);
    kb      = to_key(use_abs ? abs_b : b_i);
    lt      = ka < kb;
    gt      = ka > kb;
    pick_a_o = is_max_i ? gt : lt;
  end
endmodule

// File: rtl/fmm_select.sv
module fmm_select #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   qa_i,
  input  logic [W-1:0]   qb_i,
  input  fmm_pkg::cls_t  ca_i,
  input  fmm_pkg::cls_t  cb_i,
  input  fmm_pkg::mode_t mode_i,
  input  logic           pick_a_i,
  output logic [W-1:0]   res_o
);
  import fmm_pkg::*;

  logic both_zero;
  logic [W-1:0] ordered;

  always_comb begin
    both_zero = ca_i.zero && cb_i.zero;
    ordered   = pick_a_i ? a_i : b_i;
    if (both_zero)
      ordered = mode_i.is_max ? (a_i & b_i) : (a_i | b_i);
    res_o = ordered;
    unique case (mode_i.pol)
      POL_NUM08: begin
        if (ca_i.snan)                 res_o = qa_i;
        else if (cb_i.snan)            res_o = qb_i;
        else if (ca_i.nan && cb_i.nan) res_o = qa_i;
        else if (ca_i.nan)             res_o = b_i;
        else if (cb_i.nan)             res_o = a_i;
      end
      POL_PROP19: begin
        if (ca_i.nan)      res_o = qa_i;
        else if (cb_i.nan) res_o = qb_i;
      end
      POL_NUM19: begin
        if (ca_i.nan && cb_i.nan) res_o = qa_i;
        else if (ca_i.nan)        res_o = b_i;
        else if (cb_i.nan)        res_o = a_i;
      end
      POL_CSTYLE: begin
        if (ca_i.nan || cb_i.nan || both_zero) res_o = b_i;
      end
      default: res_o = ordered;
    endcase
  end
endmodule

// File: rtl/fmm_status.sv
module fmm_status (
  input  logic       snan_i,
  input  logic       fx_i,
  input  logic       vxsnan_i,
  input  logic       vx_other_i,
  input  logic       fex_other_i,
  input  logic       ox_i,
  input  logic       ve_i,
  output logic       fx_o,
  output logic       vxsnan_o,
  output logic       wr_en_o,
  output logic       trap_o,
  output logic [3:0] cr_o
);
  logic vx, fex;

  always_comb begin
    vxsnan_o = vxsnan_i | snan_i;
    fx_o     = fx_i | (snan_i & ~vxsnan_i);
    vx       = vxsnan_o | vx_other_i;
    fex      = fex_other_i | (vx & ve_i);
    wr_en_o  = ~ve_i | ~snan_i;
    trap_o   = ve_i & snan_i;
    cr_o     = {fx_o, fex, vx, ox_i};
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
  parameter int EXP_W = fmm_pkg::EXP_W,
  parameter int MAN_W = fmm_pkg::MAN_W,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   mode_i,
  input  logic         fx_i,
  input  logic         vxsnan_i,
  input  logic         vx_other_i,
  input  logic         fex_other_i,
  input  logic         ox_i,
  input  logic         ve_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         snan_o,
  output logic         wr_en_o,
  output logic         trap_o,
  output logic         fx_o,
  output logic         vxsnan_o,
  output logic [3:0]   cr_o
);
  import fmm_pkg::*;

  mode_t        mode;
  cls_t         cls [2];
  logic [W-1:0] opnd [2];
  logic [W-1:0] quiet [2];
  logic         pick_a, snan_c, fx_c, vxs_c, wr_c, trap_c;
  logic [3:0]   cr_c;
  logic [W-1:0] res_c;
  logic         wr_q, trap_q;

  assign mode    = mode_t'(mode_i);
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i(opnd[i]), .cls_o(cls[i]), .quiet_o(quiet[i])
    );
  end

  fmm_order #(.W(W)) u_order (
    .a_i(a_i), .b_i(b_i), .is_max_i(mode.is_max), .is_mag_i(mode.is_mag),
    .pick_a_o(pick_a)
  );

  fmm_select #(.W(W)) u_sel (
    .a_i(a_i), .b_i(b_i), .qa_i(quiet[0]), .qb_i(quiet[1]),
    .ca_i(cls[0]), .cb_i(cls[1]), .mode_i(mode), .pick_a_i(pick_a),
    .res_o(res_c)
  );

  assign snan_c = cls[0].snan | cls[1].snan;

  fmm_status u_stat (
    .snan_i(snan_c), .fx_i(fx_i), .vxsnan_i(vxsnan_i), .vx_other_i(vx_other_i),
    .fex_other_i(fex_other_i), .ox_i(ox_i), .ve_i(ve_i),
    .fx_o(fx_c), .vxsnan_o(vxs_c), .wr_en_o(wr_c), .trap_o(trap_c), .cr_o(cr_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      snan_o   <= 1'b0;
      wr_q     <= 1'b0;
      trap_q   <= 1'b0;
      fx_o     <= 1'b0;
      vxsnan_o <= 1'b0;
      cr_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_c;
        snan_o   <= snan_c;
        wr_q     <= wr_c;
        trap_q   <= trap_c;
        fx_o     <= fx_c;
        vxsnan_o <= vxs_c;
        cr_o     <= cr_c;
      end
    end
  end

  assign wr_en_o = wr_q & valid_o;
  assign trap_o  = trap_q & valid_o;

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_snan_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && snan_o) |-> vxsnan_o);
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && trap_o));
  a_r11_clean_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !snan_o) |-> wr_en_o);
  a_r12_fx_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cr_o[3] == fx_o));
endmodule

// File: tb/fp_minmax_unit_test.sv
`timescale 1ns/1ps
module fp_minmax_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [3:0] mode_i = '0;
  logic fx_i = 0, vxsnan_i = 0, vx_other_i = 0, fex_other_i = 0, ox_i = 0, ve_i = 0;
  logic valid_o, snan_o, wr_en_o, trap_o, fx_o, vxsnan_o;
  logic [63:0] result_o;
  logic [3:0] cr_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fp_minmax_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .mode_i(mode_i), .fx_i(fx_i), .vxsnan_i(vxsnan_i), .vx_other_i(vx_other_i),
    .fex_other_i(fex_other_i), .ox_i(ox_i), .ve_i(ve_i), .valid_o(valid_o),
    .result_o(result_o), .snan_o(snan_o), .wr_en_o(wr_en_o), .trap_o(trap_o),
    .fx_o(fx_o), .vxsnan_o(vxsnan_o), .cr_o(cr_o)
  );

  localparam logic [63:0] VALS [13] = '{
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
    64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000,
    64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0001,
    64'h7FF4_0000_0000_0000, 64'h7FF8_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h3FE0_0000_0000_0000};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h mode=%b)", req, act, exp, a_i, b_i, mode_i);
    end
  endtask

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction

  // behavioural model; tag names the rule that decided
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [3:0] m, output string tag);
    bit na = is_nan(a), nb = is_nan(b), sa = is_snan(a), sb = is_snan(b);
    logic [63:0] qa = a | 64'h0008_0000_0000_0000;
    logic [63:0] qb = b | 64'h0008_0000_0000_0000;
    bit zz = (a[62:0] == 0) && (b[62:0] == 0);
    real ra, rb;
    bit take_a;
    if (na || nb) begin
      case (m[1:0])
        2'b00: begin tag = "R3";
          if (sa) return qa; if (sb) return qb; if (na && nb) return qa;
          return na ? b : a; end
        2'b01: begin tag = "R4"; return na ? qa : qb; end
        2'b10: begin tag = "R5"; if (na && nb) return qa; return na ? b : a; end
        default: begin tag = "R6"; return b; end
      endcase
    end
    if (zz) begin
      if (m[1:0] == 2'b11) begin tag = "R6"; return b; end
      tag = "R7"; return m[3] ? (a & b) : (a | b);
    end
    if (m[2] && (a[62:0] != b[62:0])) begin
      tag = "R8";
      ra = $bitstoreal({1'b0, a[62:0]}); rb = $bitstoreal({1'b0, b[62:0]});
    end else begin
      tag = m[2] ? "R8" : "R9";
      ra = $bitstoreal(a); rb = $bitstoreal(b);
    end
    take_a = m[3] ? (ra > rb) : (ra < rb);
    return take_a ? a : b;
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk(valid_o == 0 && wr_en_o == 0 && trap_o == 0, "R1", valid_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 13; i++) begin
      for (int j = 0; j < 13; j++) begin
        for (int m = 0; m < 16; m++) begin
          string tag;
          logic [63:0] er;
          bit es, evs, efx, ewr, etr, evx, efex;
          logic [3:0] st;
          @(negedge clk);
          st = 4'(n * 7 + i);
          a_i = VALS[i]; b_i = VALS[j]; mode_i = 4'(m);
          vxsnan_i = st[0]; fx_i = st[1]; ve_i = st[2] & ~st[0];
          vx_other_i = st[3]; fex_other_i = st[1] ^ st[3]; ox_i = st[2];
          valid_i = 1'b1;
          n++;
          @(negedge clk);
          er   = model(a_i, b_i, mode_i, tag);
          es   = is_snan(a_i) || is_snan(b_i);
          evs  = vxsnan_i | es;
          efx  = fx_i | (es & !vxsnan_i);
          ewr  = !ve_i || !es;
          etr  = ve_i && es;
          evx  = evs | vx_other_i;
          efex = fex_other_i | (evx & ve_i);
          chk(valid_o == 1, "R1", valid_o, 1);
          chk(result_o == er, tag, result_o, er);
          chk(snan_o == es, "R2", snan_o, es);
          chk(vxsnan_o == evs && fx_o == efx, "R10", {fx_o, vxsnan_o}, {efx, evs});
          chk(wr_en_o == ewr && trap_o == etr, "R11", {wr_en_o, trap_o}, {ewr, etr});
          chk(cr_o == {efx, efex, evx, ox_i}, "R12", cr_o, {efx, efex, evx, ox_i});
          if (n % 50 == 0) begin
            valid_i = 1'b0;
            @(negedge clk);
            chk(valid_o == 0 && wr_en_o == 0 && trap_o == 0, "R1", valid_o, 0);
          end
        end
      end
    end
    valid_i = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule